// File: doc/BRIEF.md
# Dual Chroma-Key Video Fader

The block mixes two pixel streams that arrive in lockstep, one pixel per clock: a foreground stream and a background stream, each carrying 8-bit Y, U and V components. Every foreground pixel is tested against two programmable colour keys. Each key defines an inclusive window for each of Y, U and V. When all three components of the foreground pixel fall inside a key's windows, the output is a weighted blend of background and foreground. The weight is a 6-bit fade factor that belongs to that key. When no key matches, the foreground pixel passes through unchanged.

Each input stream has its own format setting: offset binary or two's complement. Two's-complement samples are turned into offset binary by flipping the MSB. This conversion happens before the key windows are tested and before the blend, and the output is always offset binary. The key limits, the two fade factors and the two format bits are set through a one-cycle register write port. The pixel path has no handshake. A valid flag travels alongside the data through a fixed three-stage pipeline.

Top module: `chroma_key_fader`

## Requirements
- R1: After reset, all twelve key limits hold 80h, both fade factors hold 3Fh, both streams are in offset-binary format, and pix_valid_o and all mix outputs are 0.
- R2: Address 14 holds the format bits. Bit 0 sets the foreground (mpeg_*) format and bit 1 sets the background (vid_*) format. 1 means offset binary. 0 means two's complement, which is converted by inverting bit 7 of every component. The mix outputs are always offset binary.
- R3: A key matches only when the converted foreground Y, U and V each satisfy lower <= value <= upper for that key.
- R4: With a key matched and its fade factor F, the weight is w = F + F[5] (range 0 to 64). Each component is computed as mix = (w*vid + (64-w)*mpeg + 32) >> 6, using the converted values.
- R5: F = 00h yields exactly the converted foreground value, and F = 3Fh yields exactly the converted background value.
- R6: When both keys match, the fade factor of key 1 is used.
- R7: When neither key matches, the output equals the converted foreground pixel.
- R8: pix_valid_o rises exactly 3 clocks after pix_valid_i, together with that pixel's result. pix_valid_o is never high without a corresponding input pixel.
- R9: The write map is as follows. Addresses 0 to 5 hold key 1 Y-low, Y-high, U-low, U-high, V-low and V-high. Addresses 6 to 11 hold the same for key 2. Address 12 holds fade 1 in cfg_wdata_i[5:0], and address 13 holds fade 2. Writes to any other address change nothing. A write in cycle N applies to pixels presented from cycle N+1 onward. A pixel presented in cycle N uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register write address |
| cfg_wdata_i | input | 8 | Register write data |
| pix_valid_i | input | 1 | Input pixel present |
| mpeg_y_i | input | 8 | Foreground Y |
| mpeg_u_i | input | 8 | Foreground U |
| mpeg_v_i | input | 8 | Foreground V |
| vid_y_i | input | 8 | Background Y |
| vid_u_i | input | 8 | Background U |
| vid_v_i | input | 8 | Background V |
| pix_valid_o | output | 1 | Mixed pixel present |
| mix_y_o | output | 8 | Mixed Y, offset binary |
| mix_u_o | output | 8 | Mixed U, offset binary |
| mix_v_o | output | 8 | Mixed V, offset binary |

## Verification
The bench builds the block with its defaults: 8-bit components, 6-bit fades and two keys. With these values both priority resolution and the full write map, including the unused address 15, can be reached. A 6-bit fade makes the weight expansion at 3Fh and the rounding offset of 32 directly observable. Pixels are driven at both inclusive window edges and one step outside them, under all four format combinations. Writes are also issued in the same cycle as a pixel, which probes the boundary at which a new setting takes effect.

// File: rtl/ckf_pkg.sv
package ckf_pkg;
  localparam int unsigned COMPS        = 3;        // lane 0 = Y, 1 = U, 2 = V
  localparam int unsigned LIMS_PER_KEY = 2 * COMPS; // low/high per lane

  function automatic int unsigned lim_index(input int unsigned comp, input int unsigned hi);
    return comp * 2 + hi;
  endfunction

  function automatic int unsigned fade_addr(input int unsigned nkeys, input int unsigned key);
    return nkeys * LIMS_PER_KEY + key;
  endfunction

  function automatic int unsigned fmt_addr(input int unsigned nkeys);
    return nkeys * (LIMS_PER_KEY + 1);
  endfunction
endpackage

// File: rtl/ckf_fmt_conv.sv
module ckf_fmt_conv
  import ckf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [COMPS-1:0][DATA_W-1:0] raw_i,
  input  logic                         straight_i,
  output logic [COMPS-1:0][DATA_W-1:0] ofs_o
);
  for (genvar c = 0; c < COMPS; c++) begin : g_lane
    assign ofs_o[c] = {raw_i[c][DATA_W-1] ^ ~straight_i, raw_i[c][DATA_W-2:0]};
  end
endmodule

// File: rtl/ckf_key_match.sv
module ckf_key_match
  import ckf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [COMPS-1:0][DATA_W-1:0]        pix_i,
  input  logic [LIMS_PER_KEY-1:0][DATA_W-1:0] lim_i,
  output logic                                hit_o
);
  logic [COMPS-1:0] in_win;

  for (genvar c = 0; c < COMPS; c++) begin : g_win
    assign in_win[c] = (pix_i[c] >= lim_i[lim_index(c, 0)]) &&
                       (pix_i[c] <= lim_i[lim_index(c, 1)]);
  end

  assign hit_o = &in_win;
endmodule

// File: rtl/ckf_blend_lane.sv
module ckf_blend_lane #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FADE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mul_en_i,
  input  logic              sum_en_i,
  input  logic [DATA_W-1:0] mpeg_i,
  input  logic [DATA_W-1:0] vid_i,
  input  logic [FADE_W:0]   w_i,
  output logic [DATA_W-1:0] mix_o
);
  localparam int unsigned    PROD_W = DATA_W + FADE_W;
  localparam logic [FADE_W:0] W_FULL = (FADE_W+1)'(1) << FADE_W;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FADE_W - 1);

  logic [FADE_W:0]     w_inv;
  logic [PROD_W-1:0]   pv_q, pm_q, sum;
  logic [DATA_W-1:0]   mix_q;

  assign w_inv = W_FULL - w_i;
  // w*v + (full-w)*m <= full*(2^DATA_W-1), so half-LSB rounding cannot carry out
  assign sum   = pv_q + pm_q + HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q  <= '0;
      pm_q  <= '0;
      mix_q <= '0;
    end else begin
      if (mul_en_i) begin
        pv_q <= PROD_W'(w_i) * PROD_W'(vid_i);
        pm_q <= PROD_W'(w_inv) * PROD_W'(mpeg_i);
      end
      if (sum_en_i) mix_q <= DATA_W'(sum >> FADE_W);
    end
  end

  assign mix_o = mix_q;
endmodule

// File: rtl/chroma_key_fader.sv
module chroma_key_fader
  import ckf_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FADE_W   = 6,
  parameter int unsigned NUM_KEYS = 2,
  parameter int unsigned ADDR_W   = $clog2(NUM_KEYS * (LIMS_PER_KEY + 1) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] mpeg_y_i,
  input  logic [DATA_W-1:0] mpeg_u_i,
  input  logic [DATA_W-1:0] mpeg_v_i,
  input  logic [DATA_W-1:0] vid_y_i,
  input  logic [DATA_W-1:0] vid_u_i,
  input  logic [DATA_W-1:0] vid_v_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] mix_y_o,
  output logic [DATA_W-1:0] mix_u_o,
  output logic [DATA_W-1:0] mix_v_o
);
  localparam logic [DATA_W-1:0] LIM_RST  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [ADDR_W-1:0] FMT_ADDR = ADDR_W'(fmt_addr(NUM_KEYS));

  typedef logic [COMPS-1:0][DATA_W-1:0] pix_t;

  // configuration
  logic [NUM_KEYS-1:0][LIMS_PER_KEY-1:0][DATA_W-1:0] lim_q;
  logic [NUM_KEYS-1:0][FADE_W-1:0]                   fade_q;
  logic                                              fmt_mpeg_sb_q, fmt_vid_sb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_KEYS; k++) begin
        for (int j = 0; j < LIMS_PER_KEY; j++) lim_q[k][j] <= LIM_RST;
        fade_q[k] <= '1;
      end
      fmt_mpeg_sb_q <= 1'b1;
      fmt_vid_sb_q  <= 1'b1;
    end else if (cfg_we_i) begin
      for (int k = 0; k < NUM_KEYS; k++) begin
        for (int j = 0; j < LIMS_PER_KEY; j++) begin
          if (cfg_addr_i == ADDR_W'(k * LIMS_PER_KEY + j)) lim_q[k][j] <= cfg_wdata_i;
        end
        if (cfg_addr_i == ADDR_W'(fade_addr(NUM_KEYS, k))) fade_q[k] <= cfg_wdata_i[FADE_W-1:0];
      end
      if (cfg_addr_i == FMT_ADDR) begin
        fmt_mpeg_sb_q <= cfg_wdata_i[0];
        fmt_vid_sb_q  <= cfg_wdata_i[1];
      end
    end
  end

  // stage 0: format conversion and key compare
  pix_t mpeg_raw, vid_raw, mpeg_ofs, vid_ofs;
  logic [NUM_KEYS-1:0] hit;

  assign mpeg_raw = {mpeg_v_i, mpeg_u_i, mpeg_y_i};
  assign vid_raw  = {vid_v_i, vid_u_i, vid_y_i};

  ckf_fmt_conv #(.DATA_W(DATA_W)) u_conv_mpeg (
    .raw_i(mpeg_raw), .straight_i(fmt_mpeg_sb_q), .ofs_o(mpeg_ofs)
  );
  ckf_fmt_conv #(.DATA_W(DATA_W)) u_conv_vid (
    .raw_i(vid_raw), .straight_i(fmt_vid_sb_q), .ofs_o(vid_ofs)
  );

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    ckf_key_match #(.DATA_W(DATA_W)) u_match (
      .pix_i(mpeg_ofs), .lim_i(lim_q[k]), .hit_o(hit[k])
    );
  end

  // stage 1: captured pixel, hits and a snapshot of the fades
  logic                            s1_valid;
  pix_t                            s1_mpeg, s1_vid;
  logic [NUM_KEYS-1:0]             s1_hit;
  logic [NUM_KEYS-1:0][FADE_W-1:0] s1_fade;
  logic [FADE_W:0]                 s1_w;
  logic                            s2_valid, s3_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_mpeg  <= '0;
      s1_vid   <= '0;
      s1_hit   <= '0;
      s1_fade  <= '0;
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else begin
      s1_valid <= pix_valid_i;
      s2_valid <= s1_valid;
      s3_valid <= s2_valid;
      if (pix_valid_i) begin
        s1_mpeg <= mpeg_ofs;
        s1_vid  <= vid_ofs;
        s1_hit  <= hit;
        s1_fade <= fade_q;
      end
    end
  end

  // lowest-numbered key wins; no hit gives weight 0, i.e. pure foreground
  always_comb begin
    s1_w = '0;
    for (int k = NUM_KEYS - 1; k >= 0; k--) begin
      if (s1_hit[k]) s1_w = {1'b0, s1_fade[k]} + (FADE_W+1)'(s1_fade[k][FADE_W-1]);
    end
  end

  // stages 2 and 3: per-lane multiply, then round and scale
  pix_t mix;

  for (genvar c = 0; c < COMPS; c++) begin : g_lane
    ckf_blend_lane #(.DATA_W(DATA_W), .FADE_W(FADE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mul_en_i(s1_valid),
      .sum_en_i(s2_valid),
      .mpeg_i  (s1_mpeg[c]),
      .vid_i   (s1_vid[c]),
      .w_i     (s1_w),
      .mix_o   (mix[c])
    );
  end

  assign pix_valid_o = s3_valid;
  assign mix_y_o     = mix[0];
  assign mix_u_o     = mix[1];
  assign mix_v_o     = mix[2];
endmodule

// File: rtl/ckf_checker.sv
module ckf_checker
  import ckf_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FADE_W   = 6,
  parameter int unsigned NUM_KEYS = 2,
  parameter int unsigned CFG_W    = 2 + NUM_KEYS * (FADE_W + LIMS_PER_KEY * DATA_W)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            pix_valid_i,
  input logic                            pix_valid_o,
  input logic                            cfg_we_i,
  input logic [CFG_W-1:0]                cfg_i,
  input logic [NUM_KEYS-1:0][FADE_W-1:0] fade_i,
  input logic                            s1_valid_i,
  input logic [NUM_KEYS-1:0]             s1_hit_i,
  input logic [FADE_W:0]                 s1_w_i,
  input logic [COMPS-1:0][DATA_W-1:0]    s1_mpeg_i,
  input logic [COMPS-1:0][DATA_W-1:0]    s1_vid_i,
  input logic [COMPS-1:0][DATA_W-1:0]    mix_i
);
  localparam logic [FADE_W:0] W_FULL = (FADE_W+1)'(1) << FADE_W;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (pix_valid_o == $past(pix_valid_i, 3)));

  assert_key1_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_i && s1_hit_i[0]) |->
      (s1_w_i == ((FADE_W+1)'($past(fade_i[0])) + (FADE_W+1)'($past(fade_i[0][FADE_W-1])))));

  assert_no_hit_zero_weight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_i && (s1_hit_i == '0)) |-> (s1_w_i == '0));

  assert_zero_weight_fg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && ($past(s1_w_i, 2) == '0)) |-> (mix_i == $past(s1_mpeg_i, 2)));

  assert_full_weight_bg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && ($past(s1_w_i, 2) == W_FULL)) |-> (mix_i == $past(s1_vid_i, 2)));

  assert_mix_in_span_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |->
      ((mix_i[0] >= $past(s1_mpeg_i[0], 2)) || (mix_i[0] >= $past(s1_vid_i[0], 2))) &&
      ((mix_i[0] <= $past(s1_mpeg_i[0], 2)) || (mix_i[0] <= $past(s1_vid_i[0], 2))));

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_we_i) |-> $stable(cfg_i));
endmodule

bind chroma_key_fader ckf_checker #(
  .DATA_W(DATA_W), .FADE_W(FADE_W), .NUM_KEYS(NUM_KEYS)
) u_ckf_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .pix_valid_o(pix_valid_o),
  .cfg_we_i   (cfg_we_i),
  .cfg_i      ({fmt_vid_sb_q, fmt_mpeg_sb_q, fade_q, lim_q}),
  .fade_i     (fade_q),
  .s1_valid_i (s1_valid),
  .s1_hit_i   (s1_hit),
  .s1_w_i     (s1_w),
  .s1_mpeg_i  (s1_mpeg),
  .s1_vid_i   (s1_vid),
  .mix_i      (mix)
);

// File: tb/chroma_key_fader_bench.sv
module chroma_key_fader_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       pix_valid = 1'b0;
  logic [7:0] my = '0, mu = '0, mv = '0, vy = '0, vu = '0, vv = '0;
  logic       pix_valid_o;
  logic [7:0] mix_y, mix_u, mix_v;

  always #4 clk = ~clk;

  chroma_key_fader u_chroma_key_fader (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .pix_valid_i(pix_valid),
    .mpeg_y_i(my), .mpeg_u_i(mu), .mpeg_v_i(mv),
    .vid_y_i(vy), .vid_u_i(vu), .vid_v_i(vv),
    .pix_valid_o(pix_valid_o),
    .mix_y_o(mix_y), .mix_u_o(mix_u), .mix_v_o(mix_v)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cyc    = 0;

  // shadow of the settings, kept from the write map
  logic [7:0] sh_lim [2][6];
  logic [5:0] sh_fade [2];
  logic       sh_fmt_m, sh_fmt_v;

  typedef struct packed {
    logic [23:0] mix;
    logic [31:0] cyc;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h (t=%0t)", req, got, want, $time);
    end
  endtask

  function automatic logic [7:0] cv(input logic [7:0] x, input logic sb);
    return sb ? x : (x ^ 8'h80);
  endfunction

  function automatic logic [23:0] model(input logic [7:0] a0, a1, a2, b0, b1, b2);
    logic [7:0] m[3];
    logic [7:0] v[3];
    int w;
    logic [23:0] r;
    m[0] = cv(a0, sh_fmt_m); m[1] = cv(a1, sh_fmt_m); m[2] = cv(a2, sh_fmt_m);
    v[0] = cv(b0, sh_fmt_v); v[1] = cv(b1, sh_fmt_v); v[2] = cv(b2, sh_fmt_v);
    w = 0;
    for (int k = 1; k >= 0; k--) begin
      bit hit = 1;
      for (int c = 0; c < 3; c++)
        if (m[c] < sh_lim[k][2*c] || m[c] > sh_lim[k][2*c+1]) hit = 0;
      if (hit) w = int'(sh_fade[k]) + int'(sh_fade[k][5]);
    end
    for (int c = 0; c < 3; c++)
      r[8*c +: 8] = 8'((w * int'(v[c]) + (64 - w) * int'(m[c]) + 32) / 64);
    return r;
  endfunction

  task automatic shadow_write(input logic [3:0] a, input logic [7:0] d);
    if (a < 4'd12)       sh_lim[a / 6][a % 6] = d;
    else if (a == 4'd12) sh_fade[0] = d[5:0];
    else if (a == 4'd13) sh_fade[1] = d[5:0];
    else if (a == 4'd14) begin sh_fmt_m = d[0]; sh_fmt_v = d[1]; end
  endtask

  task automatic push(input logic [7:0] a0, a1, a2, b0, b1, b2, input string req);
    exp_t e;
    e.mix = model(a0, a1, a2, b0, b1, b2);
    e.cyc = cyc;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic pix(input logic [7:0] a0, a1, a2, b0, b1, b2, input string req);
    @(negedge clk);
    cfg_we = 0;
    pix_valid = 1;
    my = a0; mu = a1; mv = a2; vy = b0; vu = b1; vv = b2;
    push(a0, a1, a2, b0, b1, b2, req);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    pix_valid = 0;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    shadow_write(a, d);
  endtask

  // write and pixel in the same cycle: the pixel must see the old settings
  task automatic wr_pix(input logic [3:0] a, input logic [7:0] d,
                        input logic [7:0] a0, a1, a2, b0, b1, b2, input string req);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    pix_valid = 1;
    my = a0; mu = a1; mv = a2; vy = b0; vu = b1; vv = b2;
    push(a0, a1, a2, b0, b1, b2, req);
    shadow_write(a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 0;
      pix_valid = 0;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    exp_t  e;
    string t;
    cyc <= cyc + 1;
    #2;
    if (rst_n && pix_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected valid", 32'(pix_valid_o), 32'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({mix_v, mix_u, mix_y} == e.mix, t, 32'({mix_v, mix_u, mix_y}), 32'(e.mix));
        chk(32'(cyc) - e.cyc == 32'd3, "R8 latency", 32'(cyc) - e.cyc, 32'd3);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (R8 pipeline hung)");
      summary();
      $finish;
    end
  end

  function automatic logic [7:0] pick(input logic [7:0] lo, hi);
    case ($urandom_range(0, 4))
      0: return lo - 8'd1;
      1: return lo;
      2: return hi;
      3: return hi + 8'd1;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    for (int k = 0; k < 2; k++) begin
      for (int j = 0; j < 6; j++) sh_lim[k][j] = 8'h80;
      sh_fade[k] = 6'h3F;
    end
    sh_fmt_m = 1; sh_fmt_v = 1;

    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(pix_valid_o == 0, "R1 valid in reset", 32'(pix_valid_o), 0);
    chk({mix_v, mix_u, mix_y} == 0, "R1 mix in reset", 32'({mix_v, mix_u, mix_y}), 0);
    rst_n = 1;
    idle(2);

    // R1: default windows are the single point 80h, default fade is full background
    pix(8'h80, 8'h80, 8'h80, 8'd10, 8'd20, 8'd30, "R1 default key hit");
    pix(8'h81, 8'h80, 8'h80, 8'd10, 8'd20, 8'd30, "R1 default key miss");
    pix(8'h80, 8'h80, 8'h7F, 8'd10, 8'd20, 8'd30, "R3 one lane outside");
    idle(1);

    // R9: program both keys through the write map
    wr(0, 8'd40); wr(1, 8'd60); wr(2, 8'd70); wr(3, 8'd90); wr(4, 8'd100); wr(5, 8'd120);
    wr(6, 8'd50); wr(7, 8'd200); wr(8, 8'd0); wr(9, 8'd255); wr(10, 8'd0); wr(11, 8'd255);
    wr(12, 8'h20); wr(13, 8'hD0);
    pix(8'd40, 8'd70, 8'd100, 8'd200, 8'd200, 8'd200, "R3 lower edges");
    pix(8'd60, 8'd90, 8'd120, 8'd10, 8'd250, 8'd0, "R3 upper edges");
    pix(8'd39, 8'd70, 8'd100, 8'd200, 8'd200, 8'd200, "R7 below both");
    pix(8'd45, 8'd69, 8'd100, 8'd200, 8'd200, 8'd200, "R7 U outside");
    pix(8'd61, 8'd90, 8'd120, 8'd250, 8'd3, 8'd77, "R4 key2 blend");
    pix(8'd100, 8'd91, 8'd121, 8'd0, 8'd255, 8'd128, "R4 key2 only");
    pix(8'd55, 8'd80, 8'd110, 8'd250, 8'd17, 8'd201, "R6 both match");
    idle(1);

    // R5: fade extremes
    wr(12, 8'h00);
    pix(8'd50, 8'd80, 8'd110, 8'd250, 8'd9, 8'd1, "R5 fade 00h");
    wr(12, 8'h3F);
    pix(8'd50, 8'd80, 8'd110, 8'd250, 8'd9, 8'd1, "R5 fade 3Fh");

    // R9: same-cycle write uses old value, next pixel the new one
    wr_pix(12, 8'h00, 8'd50, 8'd80, 8'd110, 8'd240, 8'd33, 8'd66, "R9 old fade");
    pix(8'd50, 8'd80, 8'd110, 8'd240, 8'd33, 8'd66, "R9 new fade");
    wr(15, 8'hFF);
    pix(8'd40, 8'd70, 8'd100, 8'd240, 8'd33, 8'd66, "R9 unused address ignored");
    idle(1);

    // R2: all four format combinations
    wr(12, 8'h2A);
    wr(14, 8'h00);
    pix(8'hB8, 8'hD0, 8'hEE, 8'h00, 8'h7F, 8'h80, "R2 both twos");
    wr(14, 8'h01);
    pix(8'd56, 8'd80, 8'd110, 8'h00, 8'h7F, 8'h80, "R2 video twos");
    wr(14, 8'h02);
    pix(8'hB8, 8'hD0, 8'hEE, 8'h00, 8'h7F, 8'h80, "R2 fg twos");
    pix(8'd56, 8'd80, 8'd110, 8'h00, 8'h7F, 8'h80, "R2 fg twos raw offset");
    wr(14, 8'h03);
    pix(8'd56, 8'd80, 8'd110, 8'h00, 8'h7F, 8'h80, "R2 both offset");

    // R4: back-to-back stream with occasional setting changes
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        wr_pix(4'($urandom_range(0, 15)), 8'($urandom),
               8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
               "R9 stream write");
      end else begin
        int k = $urandom_range(0, 1);
        logic [7:0] t0, t1, t2;
        t0 = pick(sh_lim[k][0], sh_lim[k][1]);
        t1 = pick(sh_lim[k][2], sh_lim[k][3]);
        t2 = pick(sh_lim[k][4], sh_lim[k][5]);
        pix(cv(t0, sh_fmt_m), cv(t1, sh_fmt_m), cv(t2, sh_fmt_m),
            8'($urandom), 8'($urandom), 8'($urandom), "R4 stream");
      end
    end
    idle(8);

    chk(exp_q.size() == 0, "R8 results outstanding", 32'(exp_q.size()), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule